// File: doc/BRIEF.md
# Buffered Compare Timer Channel

One timer channel built around a free-running up-counter and a small set of compare registers. Compare A sets the period: when the running counter equals compare A it returns to zero on the next clock. Compare B sets the duty: the PWM output rises when the counter clears and falls when compare B matches. A third compare, E, exists only in the primary variant of the channel. It produces a match flag and nothing else.

Each compare register has a companion buffer register. Software writes the next value into the buffer, and the channel copies that value into the compare register at a safe moment, so a new period or duty never splits a PWM cycle. The copy happens only while PWM mode is on and buffering is enabled for that pair. An 8-bit timing-select register chooses, for each pair, whether the copy happens on that pair's own compare match or on the counter clear. When buffering is off, software writes reach the compare registers directly and the buffers are never copied.

Software reaches every register through a single write port and a combinational read port, both selected by a 3-bit register code.

Top module: `bufcmp_timer_chan`

## Requirements
- R1: After reset the counter, every compare and buffer register and the timing-select register read 0, and `matchA`, `matchB`, `matchE` and `pwmOut` are 0.
- R2: Register codes on `wrSel` and `rdSel` are: 0 timing select, 1 compare A, 2 compare B, 3 compare E, 4 buffer for A, 5 buffer for B, 6 buffer for E, 7 counter (read only). In the timing-select register, bits 7..3 always read 0 and writes to them are ignored. Bit 2 is writable only in the primary variant and reads 0 otherwise.
- R3: The counter holds while `cntEn` is 0. While `cntEn` is 1 it increments on each clock, except on the clock where it equals compare A, when it becomes 0 (the counter clear).
- R4: On the clock edge at which the enabled counter equals compare A, B or E, the matching flag (`matchA`, `matchB`, `matchE`) goes high for the following cycle.
- R5: `pwmOut` becomes 1 on a counter clear and 0 on a compare B match. When both happen on the same edge, it becomes 0.
- R6: Timing-select bit n applies to pair n (bit 0 compare A, bit 1 compare B, bit 2 compare E). With bit n at 0, `pwmMode` at 1 and `bufEn[n]` at 1, the buffer is copied into compare n on that pair's own match edge.
- R7: With timing-select bit n at 1, `pwmMode` at 1 and `bufEn[n]` at 1, the copy into compare n happens on the counter-clear edge and not on that pair's own match.
- R8: A copied value is compared from the next count onward, so a pair can match again within the same period on its new value.
- R9: When `pwmMode` is 0 or `bufEn[n]` is 0, no copy into compare n happens, and software writes to compare n take effect directly.
- R10: When a copy and a software write target the same compare register on the same edge, the copied buffer value is kept.
- R11: With `PRIMARY` = 0 the E pair does not exist: compare E and its buffer read 0, and `matchE` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntEn | input | 1 | Counter runs while high |
| pwmMode | input | 1 | PWM mode; buffer copies happen only while high |
| bufEn | input | 3 | Per-pair buffer enable (bit 0 A, bit 1 B, bit 2 E) |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register code for the write |
| wrData | input | CNT_W | Write data (timing select uses bits 7..0) |
| rdSel | input | 3 | Register code for the read |
| rdData | output | CNT_W | Read data, combinational |
| count | output | CNT_W | Current counter value |
| matchA | output | 1 | Compare A match pulse |
| matchB | output | 1 | Compare B match pulse |
| matchE | output | 1 | Compare E match pulse |
| pwmOut | output | 1 | PWM level |

## Verification
Two pairs of actions can land on the same clock edge. The first is a buffer copy into compare A on its match and a software write to compare A. The bench provokes it by counting enabled edges from a parked counter so that the write strobe is sampled exactly on the matching edge. It then judges the outcome from the next period's length and from reading compare A back. The second is a clear and a compare B match. It arises when compare B equals compare A, and it is judged by `pwmOut` staying low while both flags pulse together.

// File: rtl/bct_pkg.sv
package bct_pkg;

  localparam int NUM_PAIRS = 3;
  localparam int PAIR_A    = 0;
  localparam int PAIR_B    = 1;
  localparam int PAIR_E    = 2;

  // register codes on the write and read selects
  localparam logic [2:0] SEL_CTRL     = 3'd0;
  localparam logic [2:0] SEL_CMP_BASE = 3'd1;
  localparam logic [2:0] SEL_BUF_BASE = 3'd4;
  localparam logic [2:0] SEL_CNT      = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic                 cntInc;
    logic                 cntClr;
    logic [NUM_PAIRS-1:0] xfer;
  } strobes_t;

endpackage

// File: rtl/bct_ctrl.sv
module bct_ctrl
  import bct_pkg::*;
#(
  parameter bit PRIMARY = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cntEn,
  input  logic                 pwmMode,
  input  logic [NUM_PAIRS-1:0] bufEn,
  input  logic [NUM_PAIRS-1:0] eq,
  input  logic                 wrEn,
  input  logic [2:0]           wrSel,
  input  logic [7:0]           wrByte,
  output strobes_t             strb,
  output logic [7:0]           tselVal,
  output logic [NUM_PAIRS-1:0] matchFlags,
  output logic                 pwmOut
);

  localparam logic [7:0] TSEL_MASK = PRIMARY ? 8'h07 : 8'h03;

  logic [7:0]           tselQ;
  logic [NUM_PAIRS-1:0] ev;
  logic [NUM_PAIRS-1:0] xferV;
  logic                 clrEv;

  assign ev    = eq & {NUM_PAIRS{cntEn}};
  assign clrEv = ev[PAIR_A];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tselQ <= '0;
    end else if (wrEn && (wrSel == SEL_CTRL)) begin
      tselQ <= wrByte & TSEL_MASK;
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_xfer
    if ((p < PAIR_E) || PRIMARY) begin : g_on
      assign xferV[p] = pwmMode & bufEn[p] & (tselQ[p] ? clrEv : ev[p]);
    end else begin : g_off
      assign xferV[p] = 1'b0;
    end
  end

  always_comb begin
    strb.cntInc = cntEn;
    strb.cntClr = clrEv;
    strb.xfer   = xferV;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchFlags <= '0;
      pwmOut     <= 1'b0;
    end else begin
      matchFlags <= ev;
      if (ev[PAIR_B]) begin
        pwmOut <= 1'b0;
      end else if (clrEv) begin
        pwmOut <= 1'b1;
      end
    end
  end

  assign tselVal = tselQ;

endmodule

// File: rtl/bct_datapath.sv
module bct_datapath
  import bct_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter bit PRIMARY = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strb,
  input  logic                 wrEn,
  input  logic [2:0]           wrSel,
  input  logic [CNT_W-1:0]     wrData,
  input  logic [2:0]           rdSel,
  input  logic [7:0]           tselVal,
  output logic [CNT_W-1:0]     rdData,
  output logic [CNT_W-1:0]     count,
  output logic [NUM_PAIRS-1:0] eq
);

  logic [CNT_W-1:0]                    cntQ;
  logic [NUM_PAIRS-1:0][CNT_W-1:0]     cmpVec;
  logic [NUM_PAIRS-1:0][CNT_W-1:0]     bufVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.cntClr) begin
      cntQ <= '0;
    end else if (strb.cntInc) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam logic [2:0] CMP_CODE = 3'(int'(SEL_CMP_BASE) + p);
    localparam logic [2:0] BUF_CODE = 3'(int'(SEL_BUF_BASE) + p);
    if ((p < PAIR_E) || PRIMARY) begin : g_live
      logic [CNT_W-1:0] cmpQ;
      logic [CNT_W-1:0] bufQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          cmpQ <= '0;
          bufQ <= '0;
        end else begin
          // buffered copy takes priority over a direct write
          if (strb.xfer[p]) begin
            cmpQ <= bufQ;
          end else if (wrEn && (wrSel == CMP_CODE)) begin
            cmpQ <= wrData;
          end
          if (wrEn && (wrSel == BUF_CODE)) begin
            bufQ <= wrData;
          end
        end
      end
      assign cmpVec[p] = cmpQ;
      assign bufVec[p] = bufQ;
      assign eq[p]     = (cntQ == cmpQ);
    end else begin : g_absent
      assign cmpVec[p] = '0;
      assign bufVec[p] = '0;
      assign eq[p]     = 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdSel == SEL_CTRL) begin
      rdData = CNT_W'(tselVal);
    end else if (rdSel == SEL_CNT) begin
      rdData = cntQ;
    end else begin
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (rdSel == 3'(int'(SEL_CMP_BASE) + p)) rdData = cmpVec[p];
        if (rdSel == 3'(int'(SEL_BUF_BASE) + p)) rdData = bufVec[p];
      end
    end
  end

  assign count = cntQ;

endmodule

// File: rtl/bufcmp_timer_chan.sv
module bufcmp_timer_chan
  import bct_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter bit PRIMARY = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic             pwmMode,
  input  logic [2:0]       bufEn,
  input  logic             wrEn,
  input  logic [2:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic [2:0]       rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic [CNT_W-1:0] count,
  output logic             matchA,
  output logic             matchB,
  output logic             matchE,
  output logic             pwmOut
);

  strobes_t             strb;
  logic [NUM_PAIRS-1:0] eq;
  logic [NUM_PAIRS-1:0] flags;
  logic [7:0]           tselVal;

  bct_ctrl #(.PRIMARY(PRIMARY)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cntEn      (cntEn),
    .pwmMode    (pwmMode),
    .bufEn      (bufEn),
    .eq         (eq),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrByte     (wrData[7:0]),
    .strb       (strb),
    .tselVal    (tselVal),
    .matchFlags (flags),
    .pwmOut     (pwmOut)
  );

  bct_datapath #(.CNT_W(CNT_W), .PRIMARY(PRIMARY)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .rdSel   (rdSel),
    .tselVal (tselVal),
    .rdData  (rdData),
    .count   (count),
    .eq      (eq)
  );

  assign matchA = flags[PAIR_A];
  assign matchB = flags[PAIR_B];
  assign matchE = flags[PAIR_E];

endmodule

// File: rtl/bct_checker.sv
module bct_checker #(
  parameter int CNT_W   = 16,
  parameter bit PRIMARY = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntEn,
  input logic [2:0]       rdSel,
  input logic [CNT_W-1:0] rdData,
  input logic [CNT_W-1:0] count,
  input logic             matchA,
  input logic             matchB,
  input logic             matchE,
  input logic             pwmOut
);

  logic pastValid;

  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R3: the counter is zero in the cycle the clear is flagged
  a_r3_clear_on_match: assert property (@(posedge clk) disable iff (!rstN)
    matchA |-> (count == '0));

  // R3: enabled counting steps by one unless cleared
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(cntEn) && !matchA) |-> (count == CNT_W'($past(count) + 1'b1)));

  // R3: a disabled counter holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(cntEn)) |-> $stable(count));

  // R4: a flag needs the counter running on the prior edge
  a_r4_flag_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && (matchA || matchB || matchE)) |-> $past(cntEn));

  // R5: compare B match drives the output low, also against a clear
  a_r5_pwm_low_on_b: assert property (@(posedge clk) disable iff (!rstN)
    matchB |-> !pwmOut);

  // R5: a clear without a B match drives the output high
  a_r5_pwm_high_on_clear: assert property (@(posedge clk) disable iff (!rstN)
    (matchA && !matchB) |-> pwmOut);

  // R2: reserved timing-select bits read zero
  a_r2_ctrl_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == 3'd0) |-> (rdData[CNT_W-1:3] == '0));

  // R2, R11: bit 2 reads zero in the secondary variant
  a_r11_ctrl_bit2: assert property (@(posedge clk) disable iff (!rstN)
    ((PRIMARY == 1'b0) && (rdSel == 3'd0)) |-> !rdData[2]);

  // R11: no compare E match in the secondary variant
  a_r11_no_e_match: assert property (@(posedge clk) disable iff (!rstN)
    (PRIMARY == 1'b0) |-> !matchE);

endmodule

bind bufcmp_timer_chan bct_checker #(.CNT_W(CNT_W), .PRIMARY(PRIMARY)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .cntEn  (cntEn),
  .rdSel  (rdSel),
  .rdData (rdData),
  .count  (count),
  .matchA (matchA),
  .matchB (matchB),
  .matchE (matchE),
  .pwmOut (pwmOut)
);

// File: tb/test_bufcmp_timer_chan.sv
module test_bufcmp_timer_chan;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cntEn = 1'b0;
  logic         pwmMode = 1'b0;
  logic [2:0]   bufEn = 3'b000;
  logic         wrEn = 1'b0;
  logic [2:0]   wrSel = 3'd0;
  logic [W-1:0] wrData = '0;
  logic [2:0]   rdSel = 3'd0;
  logic [W-1:0] rdData, count, rdData2, count2;
  logic         matchA, matchB, matchE, pwmOut;
  logic         matchA2, matchB2, matchE2, pwmOut2;

  int checks = 0;
  int errors = 0;
  bit sawE2 = 1'b0;

  always #5 clk = ~clk;

  bufcmp_timer_chan #(.CNT_W(W), .PRIMARY(1'b1)) i_bufcmp_timer_chan (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .pwmMode(pwmMode), .bufEn(bufEn),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(rdData),
    .count(count), .matchA(matchA), .matchB(matchB), .matchE(matchE), .pwmOut(pwmOut)
  );

  bufcmp_timer_chan #(.CNT_W(W), .PRIMARY(1'b0)) i_bufcmp_timer_chanSec (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .pwmMode(pwmMode), .bufEn(bufEn),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(rdData2),
    .count(count2), .matchA(matchA2), .matchB(matchB2), .matchE(matchE2), .pwmOut(pwmOut2)
  );

  typedef struct {
    logic [2:0]   flags;  // {E, B, A}
    logic [W-1:0] cnt;
    logic         pwm;
    string        tag;
  } exp_t;

  exp_t expQ[$];
  exp_t cur;

  // monitor: each match event pops one expected item
  always @(negedge clk) begin
    if (rstN && (matchA || matchB || matchE)) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R4: unexpected flags=%b count=%0d, expected no event", {matchE, matchB, matchA}, count);
      end else begin
        cur = expQ.pop_front();
        if ({matchE, matchB, matchA} !== cur.flags || count !== cur.cnt || pwmOut !== cur.pwm) begin
          errors++;
          $display("FAIL %s: flags=%b count=%0d pwm=%b, expected flags=%b count=%0d pwm=%b",
                   cur.tag, {matchE, matchB, matchA}, count, pwmOut, cur.flags, cur.cnt, cur.pwm);
        end
      end
    end
    if (rstN && matchE2) sawE2 = 1'b1;
  end

  task automatic pushExp(input logic [2:0] f, input logic [W-1:0] c, input logic p, input string tag);
    exp_t item;
    item.flags = f; item.cnt = c; item.pwm = p; item.tag = tag;
    expQ.push_back(item);
  endtask

  task automatic chkVal(input logic [W-1:0] act, input logic [W-1:0] expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %0h, expected %0h", tag, act, expv);
    end
  endtask

  task automatic regWrite(input logic [2:0] sel, input logic [W-1:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic chkRead(input logic [2:0] sel, input logic [W-1:0] expv, input string tag);
    rdSel = sel; #1;
    chkVal(rdData, expv, tag);
  endtask

  task automatic chkRead2(input logic [2:0] sel, input logic [W-1:0] expv, input string tag);
    rdSel = sel; #1;
    chkVal(rdData2, expv, tag);
  endtask

  // run the counter until every expected event is seen, then park it
  task automatic runDrain(input string tag);
    int n = 0;
    cntEn = 1'b1;
    do begin
      @(negedge clk); #1;
      n++;
    end while (expQ.size() != 0 && n < 500);
    cntEn = 1'b0;
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d events missing, expected 0", tag, expQ.size());
      expQ.delete();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run still busy, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkVal(count, '0, "R1 count");
    chkVal(W'({matchE, matchB, matchA, pwmOut}), '0, "R1 flags and pwm");
    chkRead(3'd0, '0, "R1 timing select");
    chkRead(3'd1, '0, "R1 compare A");
    chkRead(3'd4, '0, "R1 buffer A");

    // R2 reserved bits, R11 bit 2 absent in secondary
    regWrite(3'd0, 16'h00FF);
    chkRead(3'd0, 16'h0007, "R2 primary timing select");
    chkRead2(3'd0, 16'h0003, "R11 secondary timing select");
    regWrite(3'd0, 16'h0000);
    chkRead(3'd0, 16'h0000, "R2 timing select cleared");

    // phase 1: direct writes, no buffering (R3 R4 R5 R9)
    regWrite(3'd1, 16'd5);
    regWrite(3'd2, 16'd2);
    regWrite(3'd3, 16'd3);
    regWrite(3'd4, 16'd7);
    chkRead2(3'd3, '0, "R11 secondary compare E");
    chkRead(3'd3, 16'd3, "R9 primary compare E direct");
    for (int k = 0; k < 2; k++) begin
      pushExp(3'b010, 16'd3, 1'b0, "R4/R5 ph1 B match");
      pushExp(3'b100, 16'd4, 1'b0, "R4 ph1 E match");
      pushExp(3'b001, 16'd0, 1'b1, "R3/R5 ph1 clear");
    end
    runDrain("R3 ph1");
    chkRead(3'd1, 16'd5, "R9 compare A not copied");
    chkRead(3'd4, 16'd7, "R9 buffer A kept");
    chkRead(3'd7, 16'd0, "R3 counter parked");

    // phase 2: buffered, copy on own match (R6 R8)
    regWrite(3'd5, 16'd4);
    regWrite(3'd6, 16'd1);
    pwmMode = 1'b1; bufEn = 3'b111;
    pushExp(3'b010, 16'd3, 1'b0, "R6 ph2 B match copies");
    pushExp(3'b100, 16'd4, 1'b0, "R6 ph2 E match copies");
    pushExp(3'b010, 16'd5, 1'b0, "R8 ph2 B matches new value");
    pushExp(3'b001, 16'd0, 1'b1, "R6 ph2 clear copies A");
    pushExp(3'b100, 16'd2, 1'b1, "R6 ph2 E on new value");
    pushExp(3'b010, 16'd5, 1'b0, "R6 ph2 B on new value");
    pushExp(3'b001, 16'd0, 1'b1, "R6 ph2 new period");
    runDrain("R6 ph2");
    chkRead(3'd1, 16'd7, "R6 compare A copied");

    // phase 3: B and E copy on clear (R7)
    regWrite(3'd0, 16'h0006);
    regWrite(3'd5, 16'd2);
    regWrite(3'd6, 16'd6);
    pushExp(3'b100, 16'd2, 1'b1, "R7 ph3 E no copy on match");
    pushExp(3'b010, 16'd5, 1'b0, "R7 ph3 B no copy on match");
    pushExp(3'b001, 16'd0, 1'b1, "R7 ph3 clear copies");
    pushExp(3'b010, 16'd3, 1'b0, "R7 ph3 B new value");
    pushExp(3'b100, 16'd7, 1'b0, "R7 ph3 E new value");
    pushExp(3'b001, 16'd0, 1'b1, "R7 ph3 period");
    runDrain("R7 ph3");
    chkRead(3'd2, 16'd2, "R7 compare B");
    chkRead(3'd3, 16'd6, "R7 compare E");

    // phase 4: copy and write collide on compare A (R10)
    regWrite(3'd0, 16'h0000);
    regWrite(3'd4, 16'd3);
    pushExp(3'b010, 16'd3, 1'b0, "R10 ph4 B");
    pushExp(3'b100, 16'd7, 1'b0, "R10 ph4 E");
    pushExp(3'b001, 16'd0, 1'b1, "R10 ph4 clear");
    pushExp(3'b010, 16'd3, 1'b0, "R10 ph4 B short period");
    pushExp(3'b001, 16'd0, 1'b1, "R10 ph4 clear at 3");
    cntEn = 1'b1;
    repeat (7) @(posedge clk);
    #1 wrEn = 1'b1; wrSel = 3'd1; wrData = 16'h0055;
    @(posedge clk);
    #1 wrEn = 1'b0;
    runDrain("R10 ph4");
    chkRead(3'd1, 16'd3, "R10 compare A keeps copy");

    // phase 5: buffering off for pair A in PWM mode (R9)
    bufEn = 3'b110;
    regWrite(3'd4, 16'd2);
    for (int k = 0; k < 2; k++) begin
      pushExp(3'b010, 16'd3, 1'b0, "R9 ph5 B");
      pushExp(3'b001, 16'd0, 1'b1, "R9 ph5 clear no copy");
    end
    runDrain("R9 ph5");
    chkRead(3'd1, 16'd3, "R9 compare A unchanged");
    chkRead(3'd4, 16'd2, "R9 buffer A held");

    // phase 6: clear and B match coincide (R5)
    pwmMode = 1'b0;
    regWrite(3'd2, 16'd3);
    for (int k = 0; k < 2; k++) begin
      pushExp(3'b011, 16'd0, 1'b0, "R5 ph6 B wins over clear");
    end
    runDrain("R5 ph6");
    chkVal(W'(pwmOut), '0, "R5 pwm low after coincidence");

    chkVal(W'(sawE2), '0, "R11 secondary matchE never high");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule